// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns 32 synchronized GPIO input levels into interrupt requests. Each pin has its own settings: enable, mask, trigger kind (level or edge), polarity, a both-edge override and an optional debounce filter. The settings arrive as 32-bit vectors from a register block that sits outside this design.

Edge events are held in a per-pin latch until an end-of-interrupt strobe clears them. Level triggers follow the filtered input directly. The block reports three things: a raw status vector, a masked status vector and one combined interrupt line.

All debounce filters share one prescaler. Its divider is programmable and sets the sample tick rate. A debounced pin accepts a new level only after that level has been seen on several consecutive ticks.

Top module: `gpio_irq_detect`

## Requirements
- R1: Trigger kind is set per pin by `edge_mode_i`. A value of 1 gives edge triggering, where an event stays latched in raw status after the input returns. A value of 0 gives level triggering.
- R2: Polarity is set per pin by `pol_i`. A value of 1 selects a rising edge or a high level. A value of 0 selects a falling edge or a low level.
- R3: The both-edge override is set per pin by `both_i`. When it is 1 on an edge-triggered pin, a rising or a falling transition latches an event, whatever the value of `pol_i`.
- R4: Masked status `stat_o` equals `raw_o` with the pins whose `mask_i` bit is 1 forced to 0. `raw_o` still shows pending events on masked pins.
- R5: For one clock, `eoi_i` bit n = 1 clears the latched edge event of pin n. An `eoi_i` bit of 0 leaves its pin's latch unchanged.
- R6: When `deb_en_i` bit n is 1, a new level on pin n is accepted only once it has been sampled on 4 consecutive prescaler ticks. Ticks occur every `tick_div_i`+1 clocks. A pulse shorter than that never reaches detection.
- R7: A pin whose `en_i` bit is 0 never sets `raw_o`. Clearing `en_i` also drops any event already latched for that pin.
- R8: A level-triggered pin is not latched. Its raw bit follows the filtered input in the same cycle.
- R9: `irq_o` is the OR of all `stat_o` bits.
- R10: When an edge and an `eoi_i` clear for the same pin fall in the same cycle, the new edge wins and stays latched.
- R11: An edge on an undebounced pin appears in `raw_o` after the first clock edge that sees the new input level. It is not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Synchronized pin levels |
| en_i | input | 32 | Per-pin detection enable |
| mask_i | input | 32 | Per-pin mask, 1 hides the pin from `stat_o` |
| edge_mode_i | input | 32 | 1 = edge trigger, 0 = level trigger |
| pol_i | input | 32 | 1 = rising/high, 0 = falling/low |
| both_i | input | 32 | 1 = both edges trigger (edge mode only) |
| deb_en_i | input | 32 | Per-pin debounce enable |
| tick_div_i | input | 16 | Prescaler divider; tick every value+1 clocks |
| eoi_i | input | 32 | Write-one-to-clear strobe for latched edges |
| raw_o | output | 32 | Raw status |
| stat_o | output | 32 | Masked status |
| irq_o | output | 1 | Combined interrupt |

## Verification
Each pin is driven with a single rising transition and with a single falling transition. Every trigger setting is tried against both:

- Rising-only, falling-only and both-edge settings are told apart by which transition latches.
- Level mode is told apart from edge mode by whether raw status drops when the input returns.

A same-cycle edge and clear separates the edge-wins priority from a plain clear. Debounce is driven with a level held long enough and with a glitch two ticks long. It is also run at two divider values, to show that acceptance counts ticks and not clocks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NPINS_DEF     = 32;
  localparam int unsigned DEB_TICKS_DEF = 4;
  localparam int unsigned DIV_W_DEF     = 16;

  typedef struct packed {
    logic en;
    logic edge_mode;
    logic pol;
    logic both;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_irq_prescaler.sv
module gpio_irq_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // divider 0 ticks every cycle
  AST_TICK_ZERO_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |-> tick_o); // R6
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
  parameter int unsigned DEB_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  input  logic tick_i,
  output logic lvl_o
);
  localparam int unsigned CNT_W = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_TICKS - 1);

  logic             stable_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!en_i) begin
      // track input so enabling the filter causes no false change
      stable_q <= pin_i;
      cnt_q    <= '0;
    end else if (tick_i) begin
      if (pin_i == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        stable_q <= pin_i;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = en_i ? stable_q : pin_i;

  AST_DEB_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(stable_q)); // R6
  AST_DEB_NEEDS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != CNT_LAST) |=> $stable(stable_q)); // R6
endmodule

// File: rtl/gpio_irq_edge_cell.sv
module gpio_irq_edge_cell
  import gpio_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     lvl_i,
  input  pin_cfg_t cfg_i,
  input  logic     eoi_i,
  output logic     raw_o
);
  logic prev_q, latch_q;
  logic rise, fall, hit, lvl_act;

  assign rise    = lvl_i & ~prev_q;
  assign fall    = ~lvl_i & prev_q;
  assign hit     = cfg_i.both ? (rise | fall) : (cfg_i.pol ? rise : fall);
  assign lvl_act = cfg_i.pol ? lvl_i : ~lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      // set beats clear
      latch_q <= cfg_i.en & cfg_i.edge_mode & ((latch_q & ~eoi_i) | hit);
    end
  end

  assign raw_o = cfg_i.en & (cfg_i.edge_mode ? latch_q : lvl_act);

  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && cfg_i.edge_mode && hit && eoi_i) |=> latch_q); // R10
  AST_EOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && eoi_i && !hit) |=> !latch_q); // R5
  AST_EDGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !eoi_i && cfg_i.en && cfg_i.edge_mode) |=> latch_q); // R1
  AST_DISABLED_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.en) |=> !latch_q); // R7
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS     = NPINS_DEF,
  parameter int unsigned DEB_TICKS = DEB_TICKS_DEF,
  parameter int unsigned DIV_W     = DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] en_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] edge_mode_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] deb_en_i,
  input  logic [DIV_W-1:0] tick_div_i,
  input  logic [NPINS-1:0] eoi_i,
  output logic [NPINS-1:0] raw_o,
  output logic [NPINS-1:0] stat_o,
  output logic             irq_o
);
  logic             tick;
  logic [NPINS-1:0] filt;

  gpio_irq_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (tick_div_i),
    .tick_o (tick)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg = '{en: en_i[g], edge_mode: edge_mode_i[g], pol: pol_i[g], both: both_i[g]};

    gpio_irq_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[g]),
      .en_i   (deb_en_i[g]),
      .tick_i (tick),
      .lvl_o  (filt[g])
    );

    gpio_irq_edge_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (filt[g]),
      .cfg_i  (cfg),
      .eoi_i  (eoi_i[g]),
      .raw_o  (raw_o[g])
    );
  end

  assign stat_o = raw_o & ~mask_i;
  assign irq_o  = |stat_o;

  AST_RAW_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_o & ~en_i) == '0)); // R7
  AST_STAT_IN_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_o & ~raw_o) == '0)); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o == '0) |-> !irq_o); // R9
endmodule

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0, en = '0, mask = '0, emode = '0, pol = '0, both = '0, deb = '0, eoi = '0;
  logic [15:0] div = '0;
  logic [31:0] raw, stat;
  logic        irq;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio_irq_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .en_i(en), .mask_i(mask),
    .edge_mode_i(emode), .pol_i(pol), .both_i(both), .deb_en_i(deb),
    .tick_div_i(div), .eoi_i(eoi), .raw_o(raw), .stat_o(stat), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clean();
    en = '0; pin = '0; mask = '0; emode = '0; pol = '0; both = '0; deb = '0; eoi = '0; div = '0;
    step(2);
  endtask

  task automatic t_reset();
    chk("R7 reset raw", raw, 32'h0);
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_level();
    en[0] = 1; pol[0] = 1; step(1);
    pin[0] = 1; #1;
    chk("R8 level high follows", raw[0], 1);
    pin[0] = 0; #1;
    chk("R8 level not latched", raw[0], 0);
    pol[0] = 0; #1;
    chk("R2 level low active", raw[0], 1);
    clean();
  endtask

  task automatic t_rise();
    en[1] = 1; emode[1] = 1; pol[1] = 1; step(1);
    pin[1] = 1; #1;
    chk("R11 not before edge", raw[1], 0);
    step(1);
    chk("R11 rise latched", raw[1], 1);
    pin[1] = 0; step(2);
    chk("R1 edge stays latched", raw[1], 1);
    eoi = 32'hFFFF_FFFD; step(1); eoi = '0;
    chk("R5 eoi zero keeps", raw[1], 1);
    eoi[1] = 1; step(1); eoi = '0;
    chk("R5 eoi one clears", raw[1], 0);
    clean();
  endtask

  task automatic t_fall();
    en[2] = 1; emode[2] = 1; pol[2] = 0; step(1);
    pin[2] = 1; step(2);
    chk("R2 rise ignored falling pol", raw[2], 0);
    pin[2] = 0; step(1);
    chk("R2 fall latched", raw[2], 1);
    clean();
  endtask

  task automatic t_both();
    pin[3] = 1; step(1);
    en[3] = 1; emode[3] = 1; pol[3] = 1; both[3] = 1; step(1);
    pin[3] = 0; step(1);
    chk("R3 fall with pol rise", raw[3], 1);
    eoi[3] = 1; step(1); eoi = '0;
    pin[3] = 1; step(1);
    chk("R3 rise too", raw[3], 1);
    clean();
  endtask

  task automatic t_mask();
    en[4] = 1; pol[4] = 1; mask[4] = 1; pin[4] = 1; #1;
    chk("R4 raw shows masked", raw[4], 1);
    chk("R4 stat hides masked", stat, 0);
    chk("R9 irq low masked", {31'b0, irq}, 0);
    mask[4] = 0; #1;
    chk("R4 stat unmasked", stat, 32'h10);
    chk("R9 irq high", {31'b0, irq}, 1);
    clean();
  endtask

  task automatic t_enable();
    emode[5] = 1; pol[5] = 1; pin[5] = 1; step(2);
    chk("R7 disabled edge", raw[5], 0);
    emode[5] = 0; #1;
    chk("R7 disabled level", raw[5], 0);
    emode[5] = 1; pin[5] = 0; en[5] = 1; step(1);
    pin[5] = 1; step(1);
    chk("R7 enabled latched", raw[5], 1);
    en[5] = 0; step(1); en[5] = 1; #1;
    chk("R7 disable drops latch", raw[5], 0);
    clean();
  endtask

  task automatic t_race();
    en[6] = 1; emode[6] = 1; pol[6] = 1; step(1);
    pin[6] = 1; step(1);
    pin[6] = 0; step(1);
    chk("R10 pre latched", raw[6], 1);
    pin[6] = 1; eoi[6] = 1; step(1); eoi = '0;
    chk("R10 edge wins over eoi", raw[6], 1);
    clean();
  endtask

  task automatic t_deb();
    en[7] = 1; pol[7] = 1; deb[7] = 1; div = 0; step(2);
    pin[7] = 1; step(3);
    chk("R6 not after 3 ticks", raw[7], 0);
    step(1);
    chk("R6 after 4 ticks", raw[7], 1);
    div = 1; step(2);
    pin[7] = 0; step(6);
    chk("R6 div1 held 6 clk", raw[7], 1);
    step(4);
    chk("R6 div1 accepted", raw[7], 0);
    div = 0; step(2);
    pin[7] = 1; step(2); pin[7] = 0; step(6);
    chk("R6 glitch rejected", raw[7], 0);
    clean();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_mask();
    t_enable();
    t_race();
    t_deb();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule